// File: doc/BRIEF.md
# UART Status Flag Keeper

This block keeps the eight status flags of a serial port and drives its interrupt lines. It sits between a byte-wide register bus, which exposes a status register and a data register, and the transmit and receive engines. The engines report single-cycle events: the transmit engine reports that it has taken the pending byte and that shifting has finished. The receive engine reports a received word, a detected idle line, and parity, framing, noise and overrun errors. Each event sets its flag. Register accesses clear the flags.

Several flags do not use a plain write-to-clear. A read of the status register arms a sticky marker. The next data register access uses up that marker. If that access is a read, it clears the error and idle flags. If it is a write, it clears the shift-complete flag. The receive-ready flag is cleared by a data read or by writing 0 to its bit. The transmit-empty flag is cleared by any data write. Each interrupt output is its flag gated by an enable input. The receive-ready and overrun flags share one enable. When the port runs 9-bit words, bit 8 of the received word appears on a separate output, and the data register returns bits 7 to 0.

Top module: `uart_stat_flags`

## Requirements
- R1: After reset the status byte reads 0xC0: transmit-empty (bit 7) and shift-complete (bit 6) are 1 and all other flags are 0. With all enables high, irq reads 5'b11000.
- R2: Transmit-empty (bit 7) is set by ev_txd_taken. Any data register write clears it, whether or not the marker is armed.
- R3: Shift-complete (bit 6) is set by ev_tx_done. A data register write clears it only when the marker is armed. A data write with no armed marker leaves it set.
- R4: Receive-ready (bit 5) is set by ev_rx_byte. A status register write with wdata bit 5 at 0 clears it. A status write with bit 5 at 1 leaves it alone. A status write never changes any other flag, whatever value is written.
- R5: A data register read clears receive-ready (bit 5). It also clears idle (bit 4), overrun (bit 3), noise (bit 2), framing (bit 1) and parity (bit 0), but only when the marker is armed. Those five flags are set by ev_idle, ev_overrun, ev_noise, ev_frame and ev_parity.
- R6: A status register read arms the marker. The marker survives idle cycles and status writes. The first data register access after it uses it up, whether that access is a read or a write. A data read after that first access clears no error flag.
- R7: When a flag's set event and its clear fall in the same cycle, the flag ends up set. A read in that same cycle returns the value from before the update.
- R8: irq[4] = bit7 & irq_en[4], irq[3] = bit6 & irq_en[3], irq[2] = (bit5 | bit3) & irq_en[2], irq[1] = bit4 & irq_en[1], irq[0] = bit0 & irq_en[0].
- R9: rx_word is captured on ev_rx_byte. A data register read returns bits 7 to 0 of the captured word, and rx_bit8 shows bit 8 of it.
- R10: During a data register write, tx_load is 1 and tx_byte equals bus_wdata. At all other times tx_load is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Register access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register address (status at STAT_ADDR, data at DATA_ADDR) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational, valid while a read is presented |
| ev_txd_taken | input | 1 | Transmit engine took the pending byte |
| ev_tx_done | input | 1 | Transmit shift finished |
| ev_rx_byte | input | 1 | Receive engine delivered a word |
| rx_word | input | RX_W | Received word, valid with ev_rx_byte |
| ev_idle | input | 1 | Idle line detected |
| ev_overrun | input | 1 | Overrun detected |
| ev_noise | input | 1 | Noise detected |
| ev_frame | input | 1 | Framing error |
| ev_parity | input | 1 | Parity error |
| irq_en | input | 5 | Interrupt enables (see R8 for the bit map) |
| irq | output | 5 | Gated interrupt requests |
| rx_bit8 | output | 1 | Bit 8 of the captured received word |
| tx_load | output | 1 | Data register write strobe toward the transmit engine |
| tx_byte | output | 8 | Byte written to the data register |

## Verification
The case that needs care is an engine event landing in the same cycle as the register access that clears its flag, for example a parity error pulse during an armed data read. The sweep applies every combination of the eight event pulses together with each kind of access: none, status read, status write of 0x00 and of 0xFF, data read, and data write. It does this once with the marker armed and once with it disarmed, each time from a varied prior flag state. The bench predicts the flags from the rule that a set beats a clear. It checks the value read during the colliding cycle, which must be the value from before the update. It then reads the status back in a following cycle and compares it with the prediction.

// File: rtl/uart_flag_pkg.sv
package uart_flag_pkg;
   typedef logic [7:0] flag_vec_t;

   localparam int unsigned FB_TXE  = 7;
   localparam int unsigned FB_TC   = 6;
   localparam int unsigned FB_RXNE = 5;
   localparam int unsigned FB_IDLE = 4;
   localparam int unsigned FB_OVR  = 3;
   localparam int unsigned FB_NSE  = 2;
   localparam int unsigned FB_FRM  = 1;
   localparam int unsigned FB_PAR  = 0;

   localparam int unsigned NUM_FLAGS = 8;
   localparam int unsigned NUM_IRQ   = 5;

   localparam flag_vec_t FLAG_RST = 8'hC0;

   // mask of flags cleared by the armed data-read sequence
   localparam flag_vec_t SEQ_RD_MASK = 8'h1F;
endpackage

// File: rtl/uart_flag_cell.sv
module uart_flag_cell #(
   parameter bit RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= RST_VAL;
      else if (set) q <= 1'b1;
      else if (clr) q <= 1'b0;
   end
endmodule

// File: rtl/uart_flag_access.sv
module uart_flag_access
   import uart_flag_pkg::*;
#(
   parameter int unsigned ADDR_W    = 1,
   parameter int unsigned STAT_ADDR = 0,
   parameter int unsigned DATA_ADDR = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wd_rxne,
   output logic              st_rd,
   output logic              dr_rd,
   output logic              dr_wr,
   output logic              armed,
   output flag_vec_t         clr
);
   logic hit_st, hit_dr, st_wr;

   assign hit_st = sel && (addr == ADDR_W'(STAT_ADDR));
   assign hit_dr = sel && (addr == ADDR_W'(DATA_ADDR));
   assign st_rd  = hit_st && !wr;
   assign st_wr  = hit_st &&  wr;
   assign dr_rd  = hit_dr && !wr;
   assign dr_wr  = hit_dr &&  wr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              armed <= 1'b0;
      else if (st_rd)          armed <= 1'b1;
      else if (dr_rd || dr_wr) armed <= 1'b0;
   end

   always_comb begin
      clr          = '0;
      clr[FB_TXE]  = dr_wr;
      clr[FB_TC]   = dr_wr && armed;
      clr[FB_RXNE] = dr_rd || (st_wr && !wd_rxne);
      if (dr_rd && armed) clr = clr | SEQ_RD_MASK;
   end
endmodule

// File: rtl/uart_rx_hold.sv
module uart_rx_hold #(
   parameter int unsigned RX_W = 9
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic [RX_W-1:0] word,
   output logic [7:0]      low_byte,
   output logic            bit8
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    low_byte <= '0;
      else if (load) low_byte <= word[7:0];
   end

   generate
      if (RX_W == 9) begin : g_nine
         logic hi_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    hi_q <= 1'b0;
            else if (load) hi_q <= word[RX_W-1];
         end
         assign bit8 = hi_q;
      end else begin : g_eight
         assign bit8 = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/uart_flag_irq.sv
module uart_flag_irq
   import uart_flag_pkg::*;
(
   input  flag_vec_t            flags,
   input  logic [NUM_IRQ-1:0]   irq_en,
   output logic [NUM_IRQ-1:0]   irq
);
   logic [NUM_IRQ-1:0] src;

   assign src[4] = flags[FB_TXE];
   assign src[3] = flags[FB_TC];
   assign src[2] = flags[FB_RXNE] | flags[FB_OVR];
   assign src[1] = flags[FB_IDLE];
   assign src[0] = flags[FB_PAR];

   assign irq = src & irq_en;
endmodule

// File: rtl/uart_stat_flags.sv
module uart_stat_flags
   import uart_flag_pkg::*;
#(
   parameter int unsigned ADDR_W    = 1,
   parameter int unsigned STAT_ADDR = 0,
   parameter int unsigned DATA_ADDR = 1,
   parameter int unsigned RX_W      = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   input  logic              ev_txd_taken,
   input  logic              ev_tx_done,
   input  logic              ev_rx_byte,
   input  logic [RX_W-1:0]   rx_word,
   input  logic              ev_idle,
   input  logic              ev_overrun,
   input  logic              ev_noise,
   input  logic              ev_frame,
   input  logic              ev_parity,
   input  logic [4:0]        irq_en,
   output logic [4:0]        irq,
   output logic              rx_bit8,
   output logic              tx_load,
   output logic [7:0]        tx_byte
);
   localparam int unsigned ADDR_SPAN = 1 << ADDR_W;

   generate
      if (RX_W < 8 || RX_W > 9) begin : g_bad_rx_w
         $error("uart_stat_flags: RX_W must be 8 or 9");
      end
      if (STAT_ADDR == DATA_ADDR) begin : g_bad_map
         $error("uart_stat_flags: status and data addresses collide");
      end
      if (STAT_ADDR >= ADDR_SPAN || DATA_ADDR >= ADDR_SPAN) begin : g_bad_span
         $error("uart_stat_flags: register address outside ADDR_W");
      end
   endgenerate

   logic      st_rd, dr_rd, dr_wr, seq_armed;
   flag_vec_t flag_clr, flag_set, flag_q;
   logic [7:0] rx_low;

   uart_flag_access #(
      .ADDR_W   (ADDR_W),
      .STAT_ADDR(STAT_ADDR),
      .DATA_ADDR(DATA_ADDR)
   ) u_access (
      .clk    (clk),
      .rst_n  (rst_n),
      .sel    (bus_sel),
      .wr     (bus_wr),
      .addr   (bus_addr),
      .wd_rxne(bus_wdata[FB_RXNE]),
      .st_rd  (st_rd),
      .dr_rd  (dr_rd),
      .dr_wr  (dr_wr),
      .armed  (seq_armed),
      .clr    (flag_clr)
   );

   always_comb begin
      flag_set          = '0;
      flag_set[FB_TXE]  = ev_txd_taken;
      flag_set[FB_TC]   = ev_tx_done;
      flag_set[FB_RXNE] = ev_rx_byte;
      flag_set[FB_IDLE] = ev_idle;
      flag_set[FB_OVR]  = ev_overrun;
      flag_set[FB_NSE]  = ev_noise;
      flag_set[FB_FRM]  = ev_frame;
      flag_set[FB_PAR]  = ev_parity;
   end

   generate
      for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
         uart_flag_cell #(.RST_VAL(FLAG_RST[i])) u_cell (
            .clk  (clk),
            .rst_n(rst_n),
            .set  (flag_set[i]),
            .clr  (flag_clr[i]),
            .q    (flag_q[i])
         );
      end
   endgenerate

   uart_rx_hold #(.RX_W(RX_W)) u_rx (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (ev_rx_byte),
      .word    (rx_word),
      .low_byte(rx_low),
      .bit8    (rx_bit8)
   );

   uart_flag_irq u_irq (
      .flags (flag_q),
      .irq_en(irq_en),
      .irq   (irq)
   );

   always_comb begin
      bus_rdata = '0;
      if (st_rd)      bus_rdata = flag_q;
      else if (dr_rd) bus_rdata = rx_low;
   end

   assign tx_load = dr_wr;
   assign tx_byte = bus_wdata;
endmodule

// File: rtl/uart_stat_flags_chk.sv
module uart_stat_flags_chk
   import uart_flag_pkg::*;
(
   input logic      clk,
   input logic      rst_n,
   input flag_vec_t flag_q,
   input logic      seq_armed,
   input logic      dr_rd,
   input logic      dr_wr,
   input logic      ev_txd_taken,
   input logic      ev_tx_done,
   input logic      ev_rx_byte,
   input logic      ev_idle,
   input logic      ev_parity,
   input logic [4:0] irq_en,
   input logic [4:0] irq
);
   assert_txe_cleared_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (dr_wr && !ev_txd_taken) |=> !flag_q[FB_TXE]);

   assert_tc_needs_seq_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (dr_wr && !seq_armed && flag_q[FB_TC]) |=> flag_q[FB_TC]);

   assert_rxne_cleared_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (dr_rd && !ev_rx_byte) |=> !flag_q[FB_RXNE]);

   assert_err_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (dr_rd && !seq_armed && flag_q[FB_IDLE]) |=> flag_q[FB_IDLE]);

   assert_marker_used_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_armed && dr_rd) |=> !seq_armed);

   assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_idle || ev_parity) |=> (flag_q[FB_IDLE] || !$past(ev_idle))
                                 && (flag_q[FB_PAR] || !$past(ev_parity)));

   assert_irq_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (irq & ~irq_en) == 5'b0);

   assert_tc_irq_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
      irq[3] |-> flag_q[FB_TC]);

   // ev_tx_done is observed for completeness of the interface
   assert_tc_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ev_tx_done |=> flag_q[FB_TC]);
endmodule

bind uart_stat_flags uart_stat_flags_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .flag_q      (flag_q),
   .seq_armed   (seq_armed),
   .dr_rd       (dr_rd),
   .dr_wr       (dr_wr),
   .ev_txd_taken(ev_txd_taken),
   .ev_tx_done  (ev_tx_done),
   .ev_rx_byte  (ev_rx_byte),
   .ev_idle     (ev_idle),
   .ev_parity   (ev_parity),
   .irq_en      (irq_en),
   .irq         (irq)
);

// File: tb/uart_stat_flags_bench.sv
`timescale 1ns/100ps
module uart_stat_flags_bench;
   localparam int RX_W = 9;
   localparam int A_NONE = 0, A_STRD = 1, A_STW0 = 2, A_STW1 = 3, A_DRRD = 4, A_DRWR = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bus_sel = 0, bus_wr = 0;
   logic [0:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic ev_txd_taken = 0, ev_tx_done = 0, ev_rx_byte = 0, ev_idle = 0;
   logic ev_overrun = 0, ev_noise = 0, ev_frame = 0, ev_parity = 0;
   logic [RX_W-1:0] rx_word = '0;
   logic [4:0] irq_en = '0;
   logic [4:0] irq;
   logic rx_bit8, tx_load;
   logic [7:0] tx_byte;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   logic [7:0] m_flags = 8'hC0;
   logic       m_arm = 1'b0;
   logic [8:0] m_rx = '0;

   always #2.5 clk = ~clk;

   uart_stat_flags u_uart_stat_flags (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .ev_txd_taken(ev_txd_taken), .ev_tx_done(ev_tx_done), .ev_rx_byte(ev_rx_byte),
      .rx_word(rx_word), .ev_idle(ev_idle), .ev_overrun(ev_overrun),
      .ev_noise(ev_noise), .ev_frame(ev_frame), .ev_parity(ev_parity),
      .irq_en(irq_en), .irq(irq), .rx_bit8(rx_bit8), .tx_load(tx_load),
      .tx_byte(tx_byte)
   );

   task automatic chk(input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   function automatic logic [8:0] rxw(input logic [7:0] ev, input int a);
      return {ev[1] ^ ev[6], ev ^ 8'(a * 37)};
   endfunction

   function automatic logic [7:0] wd_of(input int a, input logic [7:0] ev);
      case (a)
         A_STW0: return 8'h00;
         A_STW1: return 8'hFF;
         A_DRWR: return ev ^ 8'h3C;
         default: return 8'h00;
      endcase
   endfunction

   // one cycle: access a plus event vector ev {txd,txdone,rx,idle,ovr,noise,frame,parity}
   task automatic step(input int a, input logic [7:0] ev, input logic [4:0] en,
                       input string tag, output logic [7:0] rd);
      logic [7:0] clr;
      logic [4:0] exp_irq;
      @(negedge clk);
      bus_sel   = (a != A_NONE);
      bus_wr    = (a == A_STW0 || a == A_STW1 || a == A_DRWR);
      bus_addr  = (a == A_DRRD || a == A_DRWR) ? 1'b1 : 1'b0;
      bus_wdata = wd_of(a, ev);
      {ev_txd_taken, ev_tx_done, ev_rx_byte, ev_idle,
       ev_overrun, ev_noise, ev_frame, ev_parity} = ev;
      rx_word = rxw(ev, a);
      irq_en  = en;
      #1;
      rd = bus_rdata;
      if (a == A_STRD) chk(tag, "status read", {24'b0, bus_rdata}, {24'b0, m_flags});
      if (a == A_DRRD) chk("R9", "data read", {24'b0, bus_rdata}, {24'b0, m_rx[7:0]});
      chk("R10", "tx_load", {31'b0, tx_load}, {31'b0, a == A_DRWR});
      if (a == A_DRWR) chk("R10", "tx_byte", {24'b0, tx_byte}, {24'b0, wd_of(a, ev)});
      @(posedge clk);
      #1;
      bus_sel = 0; bus_wr = 0; bus_addr = '0; bus_wdata = '0;
      {ev_txd_taken, ev_tx_done, ev_rx_byte, ev_idle,
       ev_overrun, ev_noise, ev_frame, ev_parity} = '0;
      clr = '0;
      if (a == A_DRWR) begin clr[7] = 1'b1; clr[6] = m_arm; end
      if (a == A_DRRD) begin clr[5] = 1'b1; clr[4:0] = {5{m_arm}}; end
      if (a == A_STW0) clr[5] = 1'b1;
      m_flags = (m_flags & ~clr) | ev;
      if (a == A_STRD) m_arm = 1'b1;
      else if (a == A_DRRD || a == A_DRWR) m_arm = 1'b0;
      if (ev[5]) m_rx = rxw(ev, a);
      exp_irq = {m_flags[7] & en[4], m_flags[6] & en[3], (m_flags[5] | m_flags[3]) & en[2],
                 m_flags[4] & en[1], m_flags[0] & en[0]};
      chk("R8", "irq", {27'b0, irq}, {27'b0, exp_irq});
      chk("R9", "rx_bit8", {31'b0, rx_bit8}, {31'b0, m_rx[8]});
   endtask

   initial begin : main
      logic [7:0] rd;
      string t;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // reset state
      chk("R1", "irq at reset", {27'b0, irq}, 32'h0);
      step(A_NONE, 8'h00, 5'h1F, "R1", rd);
      chk("R1", "irq all enabled", {27'b0, irq}, 32'h18);
      step(A_STRD, 8'h00, 5'h00, "R1", rd);
      chk("R1", "status literal", {24'b0, rd}, 32'hC0);

      // R9 directed
      step(A_NONE, 8'h20, 5'h00, "R9", rd);
      step(A_DRWR, 8'h00, 5'h00, "R2", rd);
      @(negedge clk);
      rx_word = 9'h1A5; ev_rx_byte = 1'b1;
      @(posedge clk); #1 ev_rx_byte = 1'b0; m_rx = 9'h1A5; m_flags[5] = 1'b1;
      chk("R9", "bit8 high", {31'b0, rx_bit8}, 32'h1);
      step(A_DRRD, 8'h00, 5'h00, "R9", rd);
      chk("R9", "low byte", {24'b0, rd}, 32'hA5);

      // R6 directed: marker survives idle and status write
      step(A_NONE, 8'h01, 5'h00, "R6", rd);
      step(A_STRD, 8'h00, 5'h00, "R6", rd);
      step(A_NONE, 8'h00, 5'h00, "R6", rd);
      step(A_NONE, 8'h00, 5'h00, "R6", rd);
      step(A_STW1, 8'h00, 5'h00, "R6", rd);
      step(A_DRRD, 8'h00, 5'h00, "R6", rd);
      step(A_STRD, 8'h00, 5'h00, "R6", rd);
      chk("R6", "parity cleared after kept marker", {31'b0, rd[0]}, 32'h0);
      // marker used by data write, then data read clears nothing
      step(A_NONE, 8'h01, 5'h00, "R6", rd);
      step(A_STRD, 8'h00, 5'h00, "R6", rd);
      step(A_DRWR, 8'h00, 5'h00, "R6", rd);
      step(A_DRRD, 8'h00, 5'h00, "R6", rd);
      step(A_STRD, 8'h00, 5'h00, "R6", rd);
      chk("R6", "parity kept after used marker", {31'b0, rd[0]}, 32'h1);

      // R3 directed: data write without marker keeps TC
      step(A_NONE, 8'h40, 5'h00, "R3", rd);
      step(A_DRRD, 8'h00, 5'h00, "R3", rd);
      step(A_DRWR, 8'h00, 5'h00, "R3", rd);
      step(A_STRD, 8'h00, 5'h00, "R3", rd);
      chk("R3", "TC kept", {31'b0, rd[6]}, 32'h1);
      chk("R2", "TXE cleared", {31'b0, rd[7]}, 32'h0);

      // sweep
      for (int ev = 0; ev < 256; ev++) begin
         for (int a = 0; a < 6; a++) begin
            for (int arm = 0; arm < 2; arm++) begin
               if (ev != 0) t = "R7";
               else if (a == A_DRWR) t = "R3";
               else if (a == A_DRRD) t = "R5";
               else if (a == A_STW0 || a == A_STW1) t = "R4";
               else if (a == A_STRD) t = "R6";
               else t = "R2";
               step(arm != 0 ? A_STRD : A_DRWR, 8'h00, 5'(ev) ^ 5'(a), t, rd);
               step(A_NONE, {8'(ev) >> 4 | 8'(ev) << 4} ^ 8'(a * 3), 5'h1F, t, rd);
               step(a, 8'(ev), 5'(ev >> 3) ^ 5'(a), t, rd);
               step(A_STRD, 8'h00, 5'(ev), t, rd);
            end
         end
      end

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run did not finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule